// File: doc/BRIEF.md
# Dual-Width Signed Integer Divider

This block performs signed division over several clock cycles. It has two operand sizes. In byte mode it divides a 16-bit two's-complement dividend by an 8-bit divisor. In word mode it divides a 32-bit dividend by a 16-bit divisor. Each operation returns a quotient, a remainder and an overflow flag. Division truncates toward zero, so a non-zero remainder always has the sign of the dividend.

A caller pulses `start` together with the operands and the size select. The block then raises `busy` while a restoring shift-subtract loop runs, one quotient bit per clock. It finishes with a one-cycle `done` pulse. The results stay on the outputs until the next operation finishes.

Two cases end at once, without any iteration. The first is a zero divisor. The second is an unsigned quotient of 2^n or more, where n is the operand width. In both cases the block flags overflow. When overflow is set, the quotient and remainder outputs carry no meaning.

Top module: `sdiv_dual`

## Requirements
- R1: With `wide`=0 (byte mode), the dividend is `dividend[15:0]` and the divisor is `divisor[7:0]`, both signed. `dividend[31:16]` and `divisor[15:8]` have no effect on any output.
- R2: With `wide`=1 (word mode), the signed 32-bit `dividend` is divided by the signed 16-bit `divisor`.
- R3: The quotient is truncated toward zero. The remainder equals dividend minus quotient times divisor, and a non-zero remainder has the dividend's sign. In byte mode, both results are sign-extended from 8 to 16 bits.
- R4: A zero divisor sets `ovf`. `done` rises in the cycle after `start` is accepted, and `busy` stays low throughout.
- R5: `ovf` is set when the signed quotient lies outside -2^(n-1) to 2^(n-1)-1, with n=8 in byte mode and n=16 in word mode. Otherwise `ovf` is cleared. When `ovf` is set, `quotient` and `remainder` are undefined.
- R6: An accepted operation that does not end at once holds `busy` high for exactly n+1 cycles. `done` then pulses for one cycle with `busy` low. When the divisor is zero, or |dividend|/|divisor| is 2^n or more, no `busy` cycle occurs.
- R7: `quotient`, `remainder` and `ovf` change only in a cycle where `done` is high. A `start` that arrives while `busy` is high is ignored.
- R8: After reset, `busy`, `done` and `ovf` are low, and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| wide | input | 1 | 1 selects word mode, 0 selects byte mode |
| dividend | input | 32 | Signed dividend; byte mode uses bits 15:0 |
| divisor | input | 16 | Signed divisor; byte mode uses bits 7:0 |
| busy | output | 1 | High while the iteration runs |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Signed quotient, sign-extended in byte mode |
| remainder | output | 16 | Signed remainder, sign-extended in byte mode |
| ovf | output | 1 | Overflow: zero divisor or quotient out of range |

## Verification
Byte mode is swept across every one of the 256 divisors for each of a set of dividends. The set includes the largest and smallest magnitudes, values just past ±128, and zero. This separates the in-range quotients from the two overflow paths: the early path on a large unsigned quotient, and the late path on a quotient of exactly +128. The sweep also covers every sign combination, which checks both the truncation direction and the sign of the remainder. Junk is driven on the unused upper bits throughout the sweep.

Word mode is tried with a grid of dividends and divisors around ±2^15 and ±2^31, which checks the wider boundary in the same way. The number of busy cycles is compared against each path. A separate case presents a second start in mid-operation and then holds the inputs, showing that the first result survives and stays stable.

// File: rtl/sdiv_dual.sv
module sdiv_dual #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           wide,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           ovf
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;
  st_t st;

  logic          mode_w, sd, sv;
  logic [W-1:0]  rem, quo, dvs;
  logic [CW-1:0] cnt;

  logic [DW-1:0] dvd_x, dvd_a;
  logic [W-1:0]  dvs_x, dvs_a, hi, lo;
  logic          early_ovf;

  assign dvd_x = wide ? dividend : {{W{dividend[W-1]}}, dividend[W-1:0]};
  assign dvs_x = wide ? divisor  : {{H{divisor[H-1]}}, divisor[H-1:0]};
  assign dvd_a = dvd_x[DW-1] ? -dvd_x : dvd_x;
  assign dvs_a = dvs_x[W-1]  ? -dvs_x : dvs_x;
  assign hi = wide ? dvd_a[DW-1:W] : {{H{1'b0}}, dvd_a[W-1:H]};
  assign lo = wide ? dvd_a[W-1:0]  : {dvd_a[H-1:0], {H{1'b0}}};
  assign early_ovf = (dvs_x == '0) || (hi >= dvs_a);

  logic [W:0]   t;
  logic         ge;
  logic [W-1:0] rem_n, quo_n;

  assign t     = {rem, quo[W-1]};
  assign ge    = t >= {1'b0, dvs};
  assign rem_n = ge ? (t[W-1:0] - dvs) : t[W-1:0];
  assign quo_n = {quo[W-2:0], ge};

  logic [W-1:0]  uq, half, qs, rs;
  logic          qneg, late_ovf;
  logic [CW-1:0] last;

  assign uq       = mode_w ? quo : {{H{1'b0}}, quo[H-1:0]};
  assign half     = mode_w ? {1'b1, {(W-1){1'b0}}} : {{H{1'b0}}, 1'b1, {(H-1){1'b0}}};
  assign qneg     = sd ^ sv;
  assign late_ovf = qneg ? (uq > half) : (uq >= half);
  assign qs       = qneg ? -uq : uq;
  assign rs       = sd ? -rem : rem;
  assign last     = mode_w ? CW'(W - 1) : CW'(H - 1);

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; ovf <= 1'b0;
      quotient <= '0; remainder <= '0;
      mode_w <= 1'b0; sd <= 1'b0; sv <= 1'b0;
      rem <= '0; quo <= '0; dvs <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (early_ovf) begin
            ovf  <= 1'b1;
            done <= 1'b1;
          end else begin
            mode_w <= wide;
            sd     <= dvd_x[DW-1];
            sv     <= dvs_x[W-1];
            rem    <= hi;
            quo    <= lo;
            dvs    <= dvs_a;
            cnt    <= '0;
            st     <= RUN;
          end
        end
        RUN: begin
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt + 1'b1;
          if (cnt == last) st <= FIN;
        end
        FIN: begin
          quotient  <= qs;
          remainder <= rs;
          ovf       <= late_ovf;
          done      <= 1'b1;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(ovf)));
  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dvs_x == '0) |=> (done && ovf && !busy));
  // R3
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf && remainder != '0) |-> (remainder[W-1] == sd));
endmodule

// File: tb/tb_sdiv_dual.sv
module tb_sdiv_dual;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic busy, done, ovf;
  logic [15:0] quotient, remainder;
  int errors = 0, checks = 0;

  sdiv_dual #(.W(16)) dut (.clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .ovf(ovf));

  always #10 clk = ~clk;

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit w, input logic [31:0] dd, input logic [15:0] dv,
                        output int bcnt);
    @(negedge clk);
    start = 1'b1; wide = w; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 1'b0;
    bcnt = 0;
    for (int g = 0; g < 100; g++) begin
      if (done) break;
      if (busy) bcnt++;
      @(negedge clk);
    end
  endtask

  task automatic check_op(input bit w, input logic [31:0] dd, input logic [15:0] dv,
                          input string req);
    longint a, b, q, r, mx, n, mag;
    bit eo;
    int bc, be;
    n  = w ? 16 : 8;
    a  = w ? longint'($signed(dd)) : longint'($signed(dd[15:0]));
    b  = w ? longint'($signed(dv)) : longint'($signed(dv[7:0]));
    mx = (64'sd1 <<< (n - 1)) - 1;
    if (b == 0) begin
      eo = 1'b1; be = 0; q = 0; r = 0;
    end else begin
      q = a / b; r = a % b;
      eo = (q > mx) || (q < -mx - 1);
      mag = (a < 0 ? -a : a) / (b < 0 ? -b : b);
      be = (mag >= (64'sd1 <<< n)) ? 0 : int'(n) + 1;
    end
    run_op(w, dd, dv, bc);
    chk(done == 1'b1, "R6", "done seen", longint'(done), 1);
    // R4 R5 overflow flag
    chk(ovf == eo, (b == 0) ? "R4" : "R5", "ovf", longint'(ovf), longint'(eo));
    // R6 busy length
    chk(bc == be, "R6", "busy cycles", bc, be);
    if (!eo) begin
      // R3 truncation and remainder sign, sign-extended results
      chk(quotient == q[15:0], req, "quotient", longint'($signed(quotient)), q);
      chk(remainder == r[15:0], "R3", "remainder", longint'($signed(remainder)), r);
    end
  endtask

  initial begin
    automatic int bdd[20] = '{0, 1, -1, 7, -7, 127, -128, 128, -129, 255, -256,
                              1000, -1000, 12345, -12345, 32767, -32768, 300, -301, 16384};
    automatic int wdd[14] = '{0, 5, -5, 32767, -32768, 32768, -32769, 100000, -100000,
                              2147483647, -2147483647 - 1, 65535, -65536, 1234567};
    automatic int wdv[16] = '{0, 1, -1, 2, -2, 3, -3, 7, -7, 255, -256, 32767, -32768,
                              1000, -1000, 12345};
    int bc;
    logic [15:0] q0, r0;
    logic o0;
    #50;
    // R8 reset state
    chk(busy == 0, "R8", "busy", longint'(busy), 0);
    chk(done == 0, "R8", "done", longint'(done), 0);
    chk(ovf == 0, "R8", "ovf", longint'(ovf), 0);
    chk(quotient == 0 && remainder == 0, "R8", "results", longint'(quotient), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 byte mode sweep, junk in ignored upper bits
    foreach (bdd[i])
      for (int d = -128; d < 128; d++)
        check_op(1'b0, {16'h5A3C, 16'(bdd[i])}, {8'hC3, 8'(d)}, "R1");

    // R2 word mode grid
    foreach (wdd[i])
      foreach (wdv[j])
        check_op(1'b1, 32'(wdd[i]), 16'(wdv[j]), "R2");

    // R7 start while busy is ignored, results then held
    @(negedge clk);
    start = 1'b1; wide = 1'b1; dividend = 32'd1000; divisor = 16'd7;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    start = 1'b1; dividend = 32'd9; divisor = 16'd0;
    @(negedge clk); start = 1'b0;
    for (int g = 0; g < 100; g++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(ovf == 0, "R7", "ovf after ignored start", longint'(ovf), 0);
    chk(quotient == 16'd142, "R7", "quotient", longint'(quotient), 142);
    chk(remainder == 16'd6, "R7", "remainder", longint'(remainder), 6);
    q0 = quotient; r0 = remainder; o0 = ovf;
    dividend = 32'hFFFF_0001; divisor = 16'h0003;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!done && !busy, "R7", "idle after ignored start", longint'(busy), 0);
      chk(quotient == q0 && remainder == r0 && ovf == o0, "R7", "held quotient",
          longint'(quotient), longint'(q0));
    end

    // R1 same low bits, different upper bits give same result
    check_op(1'b0, 32'hFFFF_FF9C, 16'h7F07, "R1");
    q0 = quotient;
    check_op(1'b0, 32'h0000_FF9C, 16'h0007, "R1");
    chk(quotient == q0, "R1", "upper bits ignored", longint'(quotient), longint'(q0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule